// File: doc/BRIEF.md
# Keyed Random Word Source

This block is a memory-mapped peripheral that publishes a fresh 32-bit random word at a fixed cadence. The analog noise source lives outside the block and arrives as a 32-bit input word. While generation is running, a period counter waits a fixed number of clock cycles and then copies that input word into an output data register. At the same moment it raises a data-ready flag.

Software controls the block through a small 32-bit register bus. Reads are combinational while the read enable is high. Writes and read side effects take effect at the next rising clock edge. The run control is guarded by a 24-bit key: a control write changes the run state only when its upper 24 bits carry the key. A mode bit doubles the generation period. The ready flag clears when software reads the status register, and it is raised again only by a newer word. A level interrupt output follows the flag, gated by an enable bit.

Top module: `rng_keyed_top`

## Requirements
- R1: A synchronous active-high reset clears the run state, the mode bit, the interrupt-enable bit, the ready flag and the output data register. Afterwards every register reads zero and `irqOut` is low.
- R2: A write to offset 0x00 whose bits [31:8] equal 0x524E47 loads the run state from bit 0: 1 starts generation and 0 stops it. Offset 0x00 reads the run state in bit 0.
- R3: A write to offset 0x00 whose bits [31:8] differ from 0x524E47 is ignored, and the run state is unchanged.
- R4: With mode bit 0 clear, the first word is loaded 84 clock edges after the edge that starts generation. Later words follow every 84 edges.
- R5: With bit 0 of the mode register (offset 0x04, no key needed, readable) set, the generation period is 168 clock edges.
- R6: Bit 0 of the status register at offset 0x1C is the ready flag. It is set on the edge that loads a new word.
- R7: A read of offset 0x1C clears the flag at the next edge. The flag then stays clear until a newer word is loaded. If a load coincides with the status read, the flag stays set.
- R8: While stopped, the period counter is held at zero, no word is loaded, the flag is not set, and the output data keeps its last value.
- R9: Offset 0x50 reads the last loaded word, which is the entropy input sampled on the loading edge.
- R10: `irqOut` is high exactly when the ready flag and bit 0 of the interrupt-enable register at offset 0x10 are both set.
- R11: Reads of any other offset return zero. Writes to offset 0x1C, offset 0x50 or unmapped offsets change no state. `busRdata` is zero while `busRe` is low.
- R12: Reading offset 0x50 does not change the ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 8 | Byte offset of the register access |
| busWe | input | 1 | Write enable, acts at the rising edge |
| busRe | input | 1 | Read enable; read side effects act at the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busRe is high |
| entropyIn | input | 32 | Raw random word from the noise source |
| irqOut | output | 1 | Level interrupt: ready flag AND interrupt enable |

## Verification
The embedded assertions check the following on every cycle:
- the counter is held at zero while generation is stopped;
- the counter stays inside the longer period;
- the output word changes only on a load;
- the flag rises only with a load;
- a status read without a coincident load leaves the flag clear;
- a control write with a wrong key never alters the run state.

The exact spacing of 84 versus 168 edges can only be shown by the bench's scenarios, using a cycle-by-cycle reference model. The same holds for the load-wins collision with a status read, and for the register contents seen through reads.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int BUS_W     = 32;
  localparam int KEY_W     = 24;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 24'h524E47;

  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_MODE  = 'h04;
  localparam int OFF_IEN   = 'h10;
  localparam int OFF_STAT  = 'h1C;
  localparam int OFF_DATA  = 'h50;

  // Levels handed from the register control to the generation datapath
  typedef struct packed {
    logic run;
    logic halfRate;
  } ctrlStb_t;
endpackage

// File: rtl/rng_dpath.sv
module rng_dpath
  import rng_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int FULL_PERIOD = 84,
  parameter int HALF_PERIOD = 168
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] entropyIn,
  output logic              loadStb,
  output logic [DATA_W-1:0] dataQ
);
  localparam int MAX_PERIOD = (HALF_PERIOD > FULL_PERIOD) ? HALF_PERIOD : FULL_PERIOD;
  localparam int CNT_W      = $clog2(MAX_PERIOD + 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(FULL_PERIOD - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] periodCnt;
  logic [CNT_W-1:0] lastCount;

  assign lastCount = stb.halfRate ? HALF_LAST : FULL_LAST;
  // >= so that a mode change mid-period cannot strand the counter past its limit
  assign loadStb   = stb.run && (periodCnt >= lastCount);

  always_ff @(posedge clk) begin
    if (rst) begin
      periodCnt <= '0;
    end else if (!stb.run || loadStb) begin
      periodCnt <= '0;
    end else begin
      periodCnt <= periodCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataQ <= '0;
    end else if (loadStb) begin
      dataQ <= entropyIn;
    end
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stb.run |=> (periodCnt == '0));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    periodCnt < CNT_W'(MAX_PERIOD));

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !loadStb |=> $stable(dataQ));
endmodule

// File: rtl/rng_ctrl.sv
module rng_ctrl
  import rng_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              loadStb,
  input  logic [DATA_W-1:0] dataQ,
  output ctrlStb_t          stb,
  output logic              irqOut
);
  logic runQ;
  logic halfQ;
  logic ienQ;
  logic flagQ;

  logic hitCtrl, hitMode, hitIen, hitStat, hitData;
  logic keyOk;
  logic statRead;

  assign hitCtrl  = (busAddr == ADDR_W'(OFF_CTRL));
  assign hitMode  = (busAddr == ADDR_W'(OFF_MODE));
  assign hitIen   = (busAddr == ADDR_W'(OFF_IEN));
  assign hitStat  = (busAddr == ADDR_W'(OFF_STAT));
  assign hitData  = (busAddr == ADDR_W'(OFF_DATA));
  assign keyOk    = (busWdata[DATA_W-1 -: KEY_W] == UNLOCK_KEY);
  assign statRead = busRe && hitStat;

  always_ff @(posedge clk) begin
    if (rst) begin
      runQ  <= 1'b0;
      halfQ <= 1'b0;
      ienQ  <= 1'b0;
    end else if (busWe) begin
      if (hitCtrl && keyOk) runQ  <= busWdata[0];
      if (hitMode)          halfQ <= busWdata[0];
      if (hitIen)           ienQ  <= busWdata[0];
    end
  end

  // A load wins over a coincident status read: that word has not been seen yet
  always_ff @(posedge clk) begin
    if (rst) begin
      flagQ <= 1'b0;
    end else if (loadStb) begin
      flagQ <= 1'b1;
    end else if (statRead) begin
      flagQ <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busRe) begin
      if (hitCtrl) busRdata[0] = runQ;
      if (hitMode) busRdata[0] = halfQ;
      if (hitIen)  busRdata[0] = ienQ;
      if (hitStat) busRdata[0] = flagQ;
      if (hitData) busRdata    = dataQ;
    end
  end

  assign stb.run      = runQ;
  assign stb.halfRate = halfQ;
  assign irqOut       = flagQ & ienQ;

  // R3
  bad_key_chk: assert property (@(posedge clk) disable iff (rst)
    (busWe && hitCtrl && !keyOk) |=> $stable(runQ));

  // R6
  flag_source_chk: assert property (@(posedge clk) disable iff (rst)
    (!flagQ && !loadStb) |=> !flagQ);

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (statRead && !loadStb) |=> !flagQ);

  // R12
  data_read_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (busRe && hitData && flagQ) |=> flagQ);
endmodule

// File: rtl/rng_keyed_top.sv
module rng_keyed_top
  import rng_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int FULL_PERIOD = 84,
  parameter int HALF_PERIOD = 168
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [BUS_W-1:0]  entropyIn,
  output logic              irqOut
);
  ctrlStb_t         stb;
  logic             loadStb;
  logic [BUS_W-1:0] dataQ;

  rng_ctrl #(.ADDR_W(ADDR_W), .DATA_W(BUS_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata),
    .loadStb(loadStb), .dataQ(dataQ),
    .stb(stb), .irqOut(irqOut)
  );

  rng_dpath #(.DATA_W(BUS_W), .FULL_PERIOD(FULL_PERIOD), .HALF_PERIOD(HALF_PERIOD)) u_dpath (
    .clk(clk), .rst(rst), .stb(stb),
    .entropyIn(entropyIn), .loadStb(loadStb), .dataQ(dataQ)
  );
endmodule

// File: tb/rng_keyed_top_tb.sv
module rng_keyed_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] entropyIn = 32'h1234_5678;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  bit live   = 0;

  // reference model state
  int          mCnt = 0;
  bit          mEn = 0, mHalf = 0, mIe = 0, mFlag = 0;
  logic [31:0] mData = '0;

  always #10 clk = ~clk;

  rng_keyed_top u_dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .entropyIn(entropyIn), .irqOut(irqOut)
  );

  always @(posedge clk) begin
    #2 entropyIn = entropyIn * 32'd1664525 + 32'd1013904223;
  end

  always @(posedge clk) begin
    int per;
    bit ld;
    if (rst) begin
      mCnt = 0; mEn = 0; mHalf = 0; mIe = 0; mFlag = 0; mData = '0;
    end else begin
      per = mHalf ? 168 : 84;
      ld  = mEn && (mCnt >= per - 1);
      if (!mEn || ld) mCnt = 0; else mCnt = mCnt + 1;
      if (ld) mData = entropyIn;
      if (ld) mFlag = 1;
      else if (busRe && busAddr == 8'h1C) mFlag = 0;
      if (busWe) begin
        if (busAddr == 8'h00 && busWdata[31:8] == 24'h524E47) mEn = busWdata[0];
        if (busAddr == 8'h04) mHalf = busWdata[0];
        if (busAddr == 8'h10) mIe = busWdata[0];
      end
    end
  end

  function automatic logic [31:0] modelRead();
    if (!busRe) return '0;
    case (busAddr)
      8'h00: return {31'd0, mEn};
      8'h04: return {31'd0, mHalf};
      8'h10: return {31'd0, mIe};
      8'h1C: return {31'd0, mFlag};
      8'h50: return mData;
      default: return '0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, mid-cycle
  always @(negedge clk) begin
    if (live && !rst) begin
      // R11 / R9 read data path
      chk(busRdata == modelRead(), "R11 rdata vs model", busRdata, modelRead());
      // R10
      chk(irqOut == (mFlag & mIe), "R10 irq vs model", {31'd0, irqOut}, {31'd0, mFlag & mIe});
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk); #2;
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    busAddr = a; busRe = 1'b1;
    @(negedge clk);
    d = busRdata;
    @(posedge clk); #2;
    busRe = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      @(posedge clk); #2;
      n++;
    end while (!irqOut && n < 1000);
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] saved;
    int n;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    live = 1;
    idle(1);

    // R1 reset state
    rd(8'h00, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(8'h04, v); chk(v == 0, "R1 mode", v, 0);
    rd(8'h10, v); chk(v == 0, "R1 ien", v, 0);
    rd(8'h1C, v); chk(v == 0, "R1 status", v, 0);
    rd(8'h50, v); chk(v == 0, "R1 data", v, 0);
    chk(irqOut == 0, "R1 irq", {31'd0, irqOut}, 0);

    // R3 wrong key
    wr(8'h00, 32'h1234_5601);
    rd(8'h00, v); chk(v == 0, "R3 bad key ignored", v, 0);
    idle(100);
    rd(8'h1C, v); chk(v == 0, "R8 no word while stopped", v, 0);

    // R10 interrupt enable
    wr(8'h10, 32'h1);
    rd(8'h10, v); chk(v == 1, "R10 ien reads", v, 1);

    // R2 + R4 full-rate period
    wr(8'h00, 32'h524E_4701);
    measure(n);
    chk(n == 84, "R4 full period", n, 84);
    rd(8'h00, v); chk(v == 1, "R2 run set", v, 1);
    rd(8'h50, v); chk(v == mData, "R9 data word", v, mData);
    rd(8'h1C, v); chk(v == 1, "R6 flag set", v, 1);
    rd(8'h1C, v); chk(v == 0, "R7 flag cleared", v, 0);
    chk(irqOut == 0, "R10 irq low after clear", {31'd0, irqOut}, 0);

    // R4 next word spacing; R12 data read keeps flag
    measure(n);
    chk(n == 84 - 4, "R4 steady period", n, 80);
    rd(8'h50, v);
    rd(8'h1C, v); chk(v == 1, "R12 data read keeps flag", v, 1);

    // R3 wrong key cannot stop
    wr(8'h00, 32'hAB00_0000);
    rd(8'h00, v); chk(v == 1, "R3 bad key keeps run", v, 1);

    // R2 stop, R8 hold
    wr(8'h00, 32'h524E_4700);
    rd(8'h00, v); chk(v == 0, "R2 run cleared", v, 0);
    rd(8'h1C, v);
    rd(8'h50, saved);
    idle(200);
    rd(8'h50, v); chk(v == saved, "R8 data held", v, saved);
    rd(8'h1C, v); chk(v == 0, "R8 flag stays clear", v, 0);

    // R5 half rate
    wr(8'h04, 32'h1);
    rd(8'h04, v); chk(v == 1, "R5 mode reads", v, 1);
    wr(8'h00, 32'h524E_4701);
    measure(n);
    chk(n == 168, "R5 half period", n, 168);

    // R7 load coinciding with status read keeps flag
    rd(8'h1C, v);
    while (mCnt != 167) begin @(posedge clk); #2; end
    busAddr = 8'h1C; busRe = 1'b1;
    @(posedge clk); #2;
    busRe = 1'b0;
    chk(irqOut == 1, "R7 load wins irq", {31'd0, irqOut}, 1);
    rd(8'h1C, v); chk(v == 1, "R7 load wins flag", v, 1);

    // R10 gating
    idle(170);
    wr(8'h10, 32'h0);
    chk(irqOut == 0, "R10 irq gated", {31'd0, irqOut}, 0);
    rd(8'h1C, v); chk(v == 1, "R10 flag still set", v, 1);

    // R11 unmapped and read-only offsets
    wr(8'h00, 32'h524E_4700);
    rd(8'h50, saved);
    wr(8'h50, 32'hDEAD_BEEF);
    wr(8'h1C, 32'h1);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h50, v); chk(v == saved, "R11 data not writable", v, saved);
    rd(8'h1C, v); chk(v == 0, "R11 status not writable", v, 0);
    rd(8'h08, v); chk(v == 0, "R11 unmapped reads zero", v, 0);
    rd(8'h7C, v); chk(v == 0, "R11 high unmapped", v, 0);
    chk(busRdata == 0, "R11 idle rdata", busRdata, 0);

    live = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule